// File: doc/BRIEF.md
# Wavefront SIMD Issue Engine

This block is the vector execution slice of a compute unit. It holds several SIMD units, each with sixteen integer lanes and its own small vector register file. A wavefront instruction names 64 work-items. A SIMD runs one instruction over four back-to-back cycles, one sixteen-item quarter per cycle. With the default sizes there are as many SIMDs as quarters (four). Each SIMD serves its own wavefront, so throughput stays fixed whatever the dependencies between instructions are.

Instructions enter on a single push port that names the target SIMD, and wait in a small in-order queue for that SIMD. A free-running slot counter rotates over the SIMDs. A SIMD may take its next instruction only in its own slot. The starts are therefore staggered one cycle apart, and at most one SIMD finishes an instruction in any cycle. Every quarter's result appears on that SIMD's writeback outputs. A completion pulse reports the SIMD and the wavefront tag when the last quarter is reported.

Top module: `simd_issue_cu`

## Requirements
- R1: After synchronous reset, and before any instruction is pushed, no `wb_valid` bit and no `done_valid` is high.
- R2: An instruction produces exactly four writeback cycles on its SIMD's outputs, in consecutive cycles, with `wb_quarter` 0, 1, 2, 3. Quarter q carries work-items 16q to 16q+15, and lane l of that quarter sits in bits [16l+15:16l] of the SIMD's 256-bit `wb_data` slice.
- R3: `in_op` selects the per-item result. 0 is a+b, 1 is a-b, 2 is a AND b, 3 is a OR b, 4 is the low 16 bits of a*b, 5 is imm plus the work-item index (0 to 63), and 6 or 7 copies a. All arithmetic wraps modulo 2^16.
- R4: Bit i of `in_mask` gates work-item i. A masked-off item keeps its old register value, and that old value is what the writeback reports. An instruction with an all-zero mask still runs its four quarters and completes.
- R5: `done_valid` is high for exactly one cycle per instruction, in the same cycle as that instruction's quarter-3 writeback. It carries the SIMD index in `done_simd` and the pushed wavefront tag in `done_wave`.
- R6: Starts are staggered. SIMD s reports completions only in cycles whose number, taken modulo 4, equals a fixed phase plus s. Two SIMDs therefore never complete in the same cycle.
- R7: When a SIMD's queue holds work, its next instruction starts right after quarter 3 of the current one. Successive completions of that SIMD are then exactly 4 cycles apart.
- R8: An instruction that reads a register written by the previous instruction of the same SIMD sees that previous result in full.
- R9: Each SIMD has a private register file and runs its own queue in push order. The same register number holds independent data in different SIMDs.
- R10: A SIMD with an empty queue stays idle. It raises no writeback and no completion, while the other SIMDs keep running in their own slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Push an instruction this cycle |
| in_simd | input | 2 | Target SIMD |
| in_wave | input | 4 | Wavefront tag carried to completion |
| in_op | input | 3 | Operation code |
| in_dst | input | 2 | Destination vector register |
| in_src_a | input | 2 | First source register |
| in_src_b | input | 2 | Second source register |
| in_imm | input | 16 | Immediate for the load operation |
| in_mask | input | 64 | Per-work-item execution mask |
| wb_valid | output | 4 | Per-SIMD quarter writeback strobe |
| wb_quarter | output | 8 | Per-SIMD quarter number, 2 bits each |
| wb_data | output | 1024 | Per-SIMD written quarter, 256 bits each |
| done_valid | output | 1 | Instruction completion pulse |
| done_simd | output | 2 | SIMD that completed |
| done_wave | output | 4 | Wavefront tag of the completed instruction |

## Verification
All four SIMDs are first loaded with immediate-plus-index patterns under full masks. This gives every lane a value that differs by work-item and by SIMD, so a swapped lane, quarter or register file shows up as wrong data. Every operation code then runs under several masks: all ones, a middle half, alternating items, only the first and last item, and none at all. These separate masked-item retention from the arithmetic. Chains of dependent instructions, including one burst of three to a single SIMD, separate correct register forwarding and gapless back-to-back issue from stale reads and bubbles. Idle stretches and single-SIMD bursts show whether idle units stay silent and whether the completion phases stay staggered.

// File: rtl/wfsimd_pkg.sv
package wfsimd_pkg;

  typedef enum logic [2:0] {
    VOP_ADD  = 3'd0,
    VOP_SUB  = 3'd1,
    VOP_AND  = 3'd2,
    VOP_OR   = 3'd3,
    VOP_MUL  = 3'd4,
    VOP_LDI  = 3'd5,
    VOP_CPY6 = 3'd6,
    VOP_CPY7 = 3'd7
  } vop_e;

endpackage

// File: rtl/wf_fifo.sv
module wf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: in-order queue is never overrun nor popped empty
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/vreg_bank.sv
module vreg_bank #(
  parameter int LANES = 16,
  parameter int DW    = 16,
  parameter int AW    = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*DW-1:0] wdata,
  input  logic [AW-1:0]       ra_addr,
  input  logic [AW-1:0]       rb_addr,
  input  logic [AW-1:0]       rc_addr,
  output logic [LANES*DW-1:0] ra_data,
  output logic [LANES*DW-1:0] rb_data,
  output logic [LANES*DW-1:0] rc_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] qa, qb, qc;

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*DW +: DW];
      qa <= mem[ra_addr];
      qb <= mem[rb_addr];
      qc <= mem[rc_addr];
    end

    assign ra_data[l*DW +: DW] = qa;
    assign rb_data[l*DW +: DW] = qb;
    assign rc_data[l*DW +: DW] = qc;
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import wfsimd_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 16,
  parameter int QW    = 2
) (
  input  vop_e                op,
  input  logic [LANES*DW-1:0] a,
  input  logic [LANES*DW-1:0] b,
  input  logic [DW-1:0]       imm,
  input  logic [QW-1:0]       quarter,
  output logic [LANES*DW-1:0] y
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] ai, bi, item, r;

    assign ai   = a[l*DW +: DW];
    assign bi   = b[l*DW +: DW];
    assign item = DW'(quarter) * DW'(LANES) + DW'(l);

    always_comb begin
      case (op)
        VOP_ADD: r = ai + bi;
        VOP_SUB: r = ai - bi;
        VOP_AND: r = ai & bi;
        VOP_OR:  r = ai | bi;
        VOP_MUL: r = ai * bi;
        VOP_LDI: r = imm + item;
        default: r = ai;
      endcase
    end

    assign y[l*DW +: DW] = r;
  end

endmodule

// File: rtl/simd_unit.sv
module simd_unit
  import wfsimd_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int LANES  = 16,
  parameter int WAVE   = 64,
  parameter int DW     = 16,
  parameter int NREGS  = 4,
  parameter int QDEPTH = 4,
  parameter int WID_W  = 4,
  localparam int NQ    = WAVE / LANES,
  localparam int QW    = $clog2(NQ),
  localparam int RW    = $clog2(NREGS),
  localparam int IW    = WID_W + 3 + 3*RW + DW + WAVE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [IW-1:0]       push_word,
  input  logic [QW-1:0]       slot,
  output logic                wb_valid,
  output logic [QW-1:0]       wb_quarter,
  output logic [LANES*DW-1:0] wb_data,
  output logic                fin_now,
  output logic [WID_W-1:0]    fin_wave
);

  localparam int O_IMM = WAVE;
  localparam int O_SB  = O_IMM + DW;
  localparam int O_SA  = O_SB + RW;
  localparam int O_DST = O_SA + RW;
  localparam int O_OP  = O_DST + RW;
  localparam int O_WV  = O_OP + 3;
  localparam int BW    = LANES * DW;

  logic [IW-1:0] head, cur;
  logic          q_empty, q_full, start, busy;
  logic [QW-1:0] qc;

  assign start = (slot == QW'(IDX)) && !q_empty;

  wf_fifo #(.W(IW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push), .din(push_word),
    .pop(start), .dout(head), .empty(q_empty), .full(q_full)
  );

  // quarter sequencer: pop in own slot, then four quarters back to back
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      qc   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      qc   <= '0;
    end else if (busy) begin
      if (qc == QW'(NQ-1)) busy <= 1'b0;
      else                 qc   <= qc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) cur <= head;
  end

  // stage B pipeline registers (aligned with synchronous register reads)
  logic             b_valid;
  logic [QW-1:0]    b_q;
  logic [2:0]       b_op;
  logic [RW-1:0]    b_dst;
  logic [DW-1:0]    b_imm;
  logic [LANES-1:0] b_mask;
  logic [WID_W-1:0] b_wave;

  always_ff @(posedge clk) begin
    if (rst) b_valid <= 1'b0;
    else     b_valid <= busy;
  end

  always_ff @(posedge clk) begin
    b_q    <= qc;
    b_op   <= cur[O_OP +: 3];
    b_dst  <= cur[O_DST +: RW];
    b_imm  <= cur[O_IMM +: DW];
    b_mask <= cur[qc*LANES +: LANES];
    b_wave <= cur[O_WV +: WID_W];
  end

  logic [BW-1:0]    ra_data, rb_data, rc_data, res, merged;
  logic [LANES-1:0] we;

  vreg_bank #(.LANES(LANES), .DW(DW), .AW(RW+QW)) u_bank (
    .clk(clk), .we(we), .waddr({b_dst, b_q}), .wdata(res),
    .ra_addr({cur[O_SA +: RW], qc}),
    .rb_addr({cur[O_SB +: RW], qc}),
    .rc_addr({cur[O_DST +: RW], qc}),
    .ra_data(ra_data), .rb_data(rb_data), .rc_data(rc_data)
  );

  lane_alu #(.LANES(LANES), .DW(DW), .QW(QW)) u_alu (
    .op(vop_e'(b_op)), .a(ra_data), .b(rb_data), .imm(b_imm),
    .quarter(b_q), .y(res)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign we[l] = b_valid && b_mask[l];
    assign merged[l*DW +: DW] = b_mask[l] ? res[l*DW +: DW] : rc_data[l*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) wb_valid <= 1'b0;
    else     wb_valid <= b_valid;
  end

  always_ff @(posedge clk) begin
    wb_quarter <= b_q;
    wb_data    <= merged;
  end

  assign fin_now  = b_valid && (b_q == QW'(NQ-1));
  assign fin_wave = b_wave;

  // checks on the sequencer against the shared slot counter
  logic [QW-1:0] slot_rel;
  assign slot_rel = slot - QW'(IDX) - QW'(1);

  a_r6_quarter_on_slot: assert property (@(posedge clk) disable iff (rst)
    busy |-> (qc == slot_rel));
  a_r2_quarter_step: assert property (@(posedge clk) disable iff (rst)
    (busy && qc != QW'(NQ-1)) |=> (busy && qc == $past(qc) + 1'b1));
  a_r7_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (busy && qc == QW'(NQ-1) && !q_empty) |=> (busy && qc == '0));
  a_r10_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
    (slot == QW'(IDX) && q_empty) |=> !busy);

endmodule

// File: rtl/simd_issue_cu.sv
module simd_issue_cu #(
  parameter int LANES  = 16,
  parameter int WAVE   = 64,
  parameter int DW     = 16,
  parameter int NREGS  = 4,
  parameter int QDEPTH = 4,
  parameter int WID_W  = 4,
  localparam int NSIMD = WAVE / LANES,
  localparam int QW    = $clog2(NSIMD),
  localparam int RW    = $clog2(NREGS),
  localparam int IW    = WID_W + 3 + 3*RW + DW + WAVE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [QW-1:0]             in_simd,
  input  logic [WID_W-1:0]          in_wave,
  input  logic [2:0]                in_op,
  input  logic [RW-1:0]             in_dst,
  input  logic [RW-1:0]             in_src_a,
  input  logic [RW-1:0]             in_src_b,
  input  logic [DW-1:0]             in_imm,
  input  logic [WAVE-1:0]           in_mask,
  output logic [NSIMD-1:0]          wb_valid,
  output logic [NSIMD*QW-1:0]       wb_quarter,
  output logic [NSIMD*LANES*DW-1:0] wb_data,
  output logic                      done_valid,
  output logic [QW-1:0]             done_simd,
  output logic [WID_W-1:0]          done_wave
);

  localparam int BW = LANES * DW;

  logic [QW-1:0] slot;
  logic [IW-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= (slot == QW'(NSIMD-1)) ? '0 : slot + 1'b1;
  end

  assign word = {in_wave, in_op, in_dst, in_src_a, in_src_b, in_imm, in_mask};

  logic [NSIMD-1:0] fin;
  logic [WID_W-1:0] fin_wave [NSIMD];

  for (genvar s = 0; s < NSIMD; s++) begin : g_simd
    simd_unit #(
      .IDX(s), .LANES(LANES), .WAVE(WAVE), .DW(DW), .NREGS(NREGS),
      .QDEPTH(QDEPTH), .WID_W(WID_W)
    ) u_simd (
      .clk(clk), .rst(rst),
      .push(in_valid && in_simd == QW'(s)), .push_word(word),
      .slot(slot),
      .wb_valid(wb_valid[s]),
      .wb_quarter(wb_quarter[s*QW +: QW]),
      .wb_data(wb_data[s*BW +: BW]),
      .fin_now(fin[s]), .fin_wave(fin_wave[s])
    );
  end

  logic             any_fin;
  logic [QW-1:0]    fin_sel;
  logic [WID_W-1:0] fin_tag;

  always_comb begin
    any_fin = 1'b0;
    fin_sel = '0;
    fin_tag = '0;
    for (int s = 0; s < NSIMD; s++) begin
      if (fin[s]) begin
        any_fin = 1'b1;
        fin_sel = QW'(s);
        fin_tag = fin_wave[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_valid <= 1'b0;
    else     done_valid <= any_fin;
  end

  always_ff @(posedge clk) begin
    done_simd <= fin_sel;
    done_wave <= fin_tag;
  end

  // R6: stagger keeps last quarters of different SIMDs apart
  a_r6_single_finish: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fin));
  // R5: completion coincides with that SIMD's quarter-3 writeback
  a_r5_done_with_last_quarter: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (wb_valid[done_simd] && wb_quarter[done_simd*QW +: QW] == QW'(NSIMD-1)));

endmodule

// File: tb/simd_issue_cu_test.sv
module simd_issue_cu_test;

  localparam int NS = 4;
  localparam int BW = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   in_simd = '0;
  logic [3:0]   in_wave = '0;
  logic [2:0]   in_op = '0;
  logic [1:0]   in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [15:0]  in_imm = '0;
  logic [63:0]  in_mask = '0;
  logic [3:0]   wb_valid;
  logic [7:0]   wb_quarter;
  logic [1023:0] wb_data;
  logic         done_valid;
  logic [1:0]   done_simd;
  logic [3:0]   done_wave;

  always #2 clk = ~clk;

  simd_issue_cu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_simd(in_simd),
    .in_wave(in_wave), .in_op(in_op), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
    .in_mask(in_mask), .wb_valid(wb_valid), .wb_quarter(wb_quarter),
    .wb_data(wb_data), .done_valid(done_valid), .done_simd(done_simd),
    .done_wave(done_wave)
  );

  typedef struct packed {
    logic [1:0]    q;
    logic          fin;
    logic [3:0]    wave;
    logic [1:0]    tag;
    logic [BW-1:0] data;
  } exp_t;

  exp_t        expq [NS][$];
  int          done_log [NS][$];
  logic [15:0] mdl [NS][4][64];
  int n_chk = 0, n_fail = 0, cyc = 0, phase_ref = -1;
  bit finished = 1'b0;
  exp_t e;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic string tagname(input logic [1:0] t);
    case (t)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // driver: model the instruction, queue its four expected quarters, push it
  task automatic push(input int s, input int wv, input int op, input int d,
                      input int a, input int b, input logic [15:0] imm,
                      input logic [63:0] mask, input logic [1:0] tag);
    logic [15:0] nv [64];
    logic [15:0] va, vb, r;
    exp_t x;
    for (int i = 0; i < 64; i++) begin
      va = mdl[s][a][i];
      vb = mdl[s][b][i];
      case (op)
        0: r = va + vb;
        1: r = va - vb;
        2: r = va & vb;
        3: r = va | vb;
        4: r = va * vb;
        5: r = imm + 16'(i);
        default: r = va;
      endcase
      nv[i] = mask[i] ? r : mdl[s][d][i];
    end
    for (int i = 0; i < 64; i++) mdl[s][d][i] = nv[i];
    for (int q = 0; q < 4; q++) begin
      x.q = 2'(q);
      x.fin = (q == 3);
      x.wave = 4'(wv);
      x.tag = tag;
      for (int l = 0; l < 16; l++) x.data[l*16 +: 16] = nv[q*16 + l];
      expq[s].push_back(x);
    end
    in_valid = 1'b1;
    in_simd = 2'(s);
    in_wave = 4'(wv);
    in_op = 3'(op);
    in_dst = 2'(d);
    in_src_a = 2'(a);
    in_src_b = 2'(b);
    in_imm = imm;
    in_mask = mask;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()) != 0
           && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 1000, "R2", "pending quarters reported", BW'(n), BW'(0));
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop and compare per-SIMD scoreboard entries
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      for (int s = 0; s < NS; s++) begin
        if (wb_valid[s]) begin
          if (expq[s].size() == 0) begin
            chk(1'b0, "R10", "writeback from idle SIMD", BW'(s), BW'(0));
          end else begin
            e = expq[s].pop_front();
            chk(wb_quarter[s*2 +: 2] == e.q, "R2", "quarter number",
                BW'(wb_quarter[s*2 +: 2]), BW'(e.q));
            chk(wb_data[s*BW +: BW] == e.data, tagname(e.tag), "quarter data",
                wb_data[s*BW +: BW], e.data);
            chk((done_valid && int'(done_simd) == s) == e.fin, "R5",
                "completion pulse", BW'(done_valid), BW'(e.fin));
            if (e.fin) begin
              chk(done_wave == e.wave, "R5", "completion wave tag",
                  BW'(done_wave), BW'(e.wave));
              done_log[s].push_back(cyc);
              if (phase_ref < 0) phase_ref = ((cyc - s) % 4 + 4) % 4;
              else chk(((cyc - s) % 4 + 4) % 4 == phase_ref, "R6",
                       "completion phase", BW'(((cyc - s) % 4 + 4) % 4), BW'(phase_ref));
            end
          end
        end
      end
      if (done_valid && !wb_valid[done_simd])
        chk(1'b0, "R5", "completion without writeback", BW'(done_simd), BW'(0));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset
    for (int k = 0; k < 4; k++) begin
      chk(wb_valid == 4'b0 && !done_valid, "R1", "outputs after reset",
          BW'({wb_valid, done_valid}), BW'(0));
      @(negedge clk);
    end

    // load distinct patterns into every register of every SIMD (R3 op 5)
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < NS; s++)
        push(s, s + 1, 5, r, 0, 0, 16'(16'h100 * (s + 1) + r * 16'h37), '1, 2'd0);
    drain();

    // operations under varied masks, round robin over SIMDs
    push(0, 1, 0, 2, 0, 1, 16'h0, '1, 2'd0);                        // R3 add
    push(1, 2, 1, 3, 0, 1, 16'h0, 64'h0000_FFFF_FFFF_0000, 2'd1);   // R4 sub, middle half
    push(2, 3, 2, 0, 1, 2, 16'h0, '1, 2'd0);                        // R3 and
    push(3, 4, 3, 1, 2, 3, 16'h0, 64'h5555_5555_5555_5555, 2'd1);   // R4 or, alternate
    push(0, 1, 4, 3, 2, 2, 16'h0, '1, 2'd2);                        // R8 mul on fresh r2
    push(1, 2, 6, 0, 3, 0, 16'h0, '1, 2'd2);                        // R8 copy of partial r3
    push(2, 3, 0, 1, 0, 0, 16'h0, 64'h0, 2'd1);                     // R4 empty mask
    push(3, 4, 4, 2, 1, 0, 16'h0, 64'h8000_0000_0000_0001, 2'd1);   // R4 edge items
    push(0, 1, 7, 1, 3, 0, 16'h0, '1, 2'd0);                        // R3 copy via 7
    push(1, 2, 2, 1, 0, 2, 16'h0, 64'hFFFF_0000_0000_FFFF, 2'd1);   // R4 outer quarters
    push(2, 3, 1, 2, 1, 3, 16'h0, '1, 2'd0);                        // R3 sub wrap
    push(3, 4, 5, 0, 0, 0, 16'hFFF0, '1, 2'd0);                     // R3 load wrap
    for (int s = 0; s < NS; s++)
      push(s, s + 1, 3, 3, 0, 0, 16'h0, '1, 2'd3);                  // R9 same regs, own data
    drain();

    // R7/R8: back-to-back dependent chain on one SIMD, others idle (R10)
    for (int k = 0; k < 3; k++) push(2, 3, 0, 1, 1, 0, 16'h0, '1, 2'd2);
    drain();
    n = done_log[2].size();
    chk(done_log[2][n-1] - done_log[2][n-2] == 4, "R7", "gap of last completions",
        BW'(done_log[2][n-1] - done_log[2][n-2]), BW'(4));
    chk(done_log[2][n-2] - done_log[2][n-3] == 4, "R7", "gap of earlier completions",
        BW'(done_log[2][n-2] - done_log[2][n-3]), BW'(4));

    // R6: each SIMD's phase is its index ahead of SIMD 0
    for (int s = 1; s < NS; s++)
      chk(((done_log[s][0] - done_log[0][0]) % 4 + 4) % 4 == s, "R6", "relative phase",
          BW'(((done_log[s][0] - done_log[0][0]) % 4 + 4) % 4), BW'(s));

    // R10: with all queues empty nothing moves
    for (int k = 0; k < 16; k++) begin
      chk(wb_valid == 4'b0 && !done_valid, "R10", "idle outputs",
          BW'({wb_valid, done_valid}), BW'(0));
      @(negedge clk);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule